// File: doc/BRIEF.md
# Repeating BCD alarm comparator

This block holds an alarm time made of four BCD bytes: seconds, minutes, hours and day of month. A running time-of-day counter elsewhere supplies the current time in BCD, together with a strobe that is high for one clock cycle each second. On every strobe the block compares the alarm against the current time. When they agree it raises its interrupt output for a single clock cycle.

Bit 7 of each alarm byte is a "don't care" flag. The pattern of the four flags selects how often the alarm repeats:

- once per month, when every field must match;
- once per day;
- once per hour;
- once per minute;
- once per second.

Software loads the alarm through a byte-wide register port. Writes that do not decode to a legal value for their field are dropped. The value stored, including the flag bit, reads back exactly as written.

Top module: `bcd_alarm`

## Requirements
- R1: After reset all four alarm registers read 0x00 and `irq_o` is low.
- R2: Address 0 holds seconds and address 1 holds minutes. A write is stored as the full byte only when its low 7 bits are valid BCD: low digit at most 9 and value 00..59. Any other write leaves the register unchanged.
- R3: Address 2 holds hours. A write is stored as the full byte only when its low 6 bits are valid BCD in 00..23. Any other write leaves the register unchanged.
- R4: Address 3 holds the day of month. A write is stored as the full byte only when its low 5 bits are valid BCD in 01..19. A value of zero, or a low digit above 9, leaves the register unchanged.
- R5: `rd_data_o` shows, in the same cycle, the stored byte at `reg_addr_i`, with bit 7 included.
- R6: With all four bit-7 flags clear, a strobe raises the interrupt only when seconds, minutes, hours and date all equal the current time. Only the low 7, 7, 6 and 5 bits of the fields are compared.
- R7: With only the date flag set, a strobe raises the interrupt when seconds, minutes and hours match. The date is ignored.
- R8: With only the date and hours flags set, seconds and minutes must match.
- R9: With only the date, hours and minutes flags set, seconds alone must match.
- R10: With any other flag pattern, every strobe raises the interrupt, whatever the current time.
- R11: `irq_o` is high for exactly the one cycle after a qualifying strobe. It stays low in every other cycle, including cycles where the time matches but no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 sec, 1 min, 2 hour, 3 date |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Stored byte at reg_addr_i |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_date_i | input | 5 | Current day of month, BCD |
| sec_tick_i | input | 1 | One-cycle strobe once per second |
| irq_o | output | 1 | One-cycle alarm pulse |

## Verification
The hardest states to reach are the intermediate repeat rates. They need one exact flag pattern across four separately written registers, and each of those bytes must still pass its own legality check while carrying bit 7. The stimulus first builds a full four-field match. It then sets the flags one field at a time, from date downward. At each step it moves the newly ignored field of the current time away from the alarm, and moves the lowest still-compared field to show that it is still checked. A pattern outside the four named ones, with only the seconds flag set, shows the every-second case.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int BYTE_W     = 8;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } field_e;

  // Ordering matters: a field of index i is compared when rate <= 3 - i.
  typedef enum logic [2:0] {
    RPT_MONTH = 3'd0,
    RPT_DAY   = 3'd1,
    RPT_HOUR  = 3'd2,
    RPT_MIN   = 3'd3,
    RPT_SEC   = 3'd4
  } rate_e;

  function automatic int unsigned field_bits(input int unsigned idx);
    case (idx)
      0, 1:    field_bits = 7;
      2:       field_bits = 6;
      default: field_bits = 5;
    endcase
  endfunction

  function automatic int unsigned field_min(input int unsigned idx);
    field_min = (idx == 3) ? 1 : 0;
  endfunction

  function automatic int unsigned field_max(input int unsigned idx);
    case (idx)
      0, 1:    field_max = 59;
      2:       field_max = 23;
      default: field_max = 19;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_mask(input int unsigned idx);
    field_mask = BYTE_W'((1 << field_bits(idx)) - 1);
  endfunction

  function automatic logic field_ok(input int unsigned idx, input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] m;
    int unsigned tens;
    int unsigned units;
    int unsigned val;
    m     = v & field_mask(idx);
    tens  = {28'd0, m[7:4]};
    units = {28'd0, m[3:0]};
    val   = tens * 10 + units;
    field_ok = (units <= 9) && (val >= field_min(idx)) && (val <= field_max(idx));
  endfunction

endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs
  import bcd_alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we_i,
  input  logic [SEL_W-1:0]                    addr_i,
  input  logic [BYTE_W-1:0]                   wdata_i,
  output logic [BYTE_W-1:0]                   rdata_o,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]   regs_o
);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] reg_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] reg_d;
  logic [NUM_FIELDS-1:0]             load_en;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
    logic legal;

    always_comb begin
      legal      = field_ok(i, wdata_i);
      load_en[i] = we_i && (addr_i == MY_SEL) && legal;
      reg_d[i]   = load_en[i] ? wdata_i : reg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[i] <= '0;
      end else if (load_en[i]) begin
        reg_q[i] <= reg_d[i];
      end
    end

    // R2 R3 R4
    wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == MY_SEL && !field_ok(i, wdata_i)) |=> $stable(reg_q[i]));

    // R2 R3 R4
    wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == MY_SEL && field_ok(i, wdata_i)) |=> (reg_q[i] == $past(wdata_i)));
  end

  always_comb begin
    rdata_o = reg_q[addr_i];
    regs_o  = reg_q;
  end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] now_i,
  output rate_e                             rate_o,
  output logic                              match_o
);

  logic [NUM_FIELDS-1:0] dont_care;
  logic [NUM_FIELDS-1:0] equal;
  logic [NUM_FIELDS-1:0] compare_en;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam logic [BYTE_W-1:0] FMASK = field_mask(i);
    localparam logic [2:0]        LIMIT = 3'(NUM_FIELDS - 1 - i);
    always_comb begin
      dont_care[i]  = alarm_i[i][BYTE_W-1];
      equal[i]      = (alarm_i[i] & FMASK) == (now_i[i] & FMASK);
      compare_en[i] = (rate_o <= LIMIT);
    end
  end

  always_comb begin
    case ({dont_care[FLD_DATE], dont_care[FLD_HOUR], dont_care[FLD_MIN], dont_care[FLD_SEC]})
      4'b0000: rate_o = RPT_MONTH;
      4'b1000: rate_o = RPT_DAY;
      4'b1100: rate_o = RPT_HOUR;
      4'b1110: rate_o = RPT_MIN;
      default: rate_o = RPT_SEC;
    endcase
    match_o = &(equal | ~compare_en);
  end

endmodule

// File: rtl/bcd_alarm_pulse.sv
module bcd_alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  output logic irq_o
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = tick_i && match_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R11
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick_i));

endmodule

// File: rtl/bcd_alarm.sv
module bcd_alarm
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        rd_data_o,
  input  logic [6:0]        cur_sec_i,
  input  logic [6:0]        cur_min_i,
  input  logic [5:0]        cur_hour_i,
  input  logic [4:0]        cur_date_i,
  input  logic              sec_tick_i,
  output logic              irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_regs;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] now_bus;
  rate_e                             rate;
  logic                              match;

  always_comb begin
    now_bus[FLD_SEC]  = BYTE_W'(cur_sec_i);
    now_bus[FLD_MIN]  = BYTE_W'(cur_min_i);
    now_bus[FLD_HOUR] = BYTE_W'(cur_hour_i);
    now_bus[FLD_DATE] = BYTE_W'(cur_date_i);
  end

  bcd_alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (rd_data_o),
    .regs_o  (alarm_regs)
  );

  bcd_alarm_match u_match (
    .alarm_i (alarm_regs),
    .now_i   (now_bus),
    .rate_o  (rate),
    .match_o (match)
  );

  bcd_alarm_pulse u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (sec_tick_i),
    .match_i (match),
    .irq_o   (irq_o)
  );

  // R10
  every_second_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sec_tick_i && alarm_regs[FLD_SEC][7] && !reg_we_i) |=> irq_o);

  // R6
  monthly_full_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sec_tick_i && rate == RPT_MONTH &&
     alarm_regs[FLD_DATE][4:0] != cur_date_i) |=> !irq_o);

endmodule

// File: tb/test_bcd_alarm.sv
module test_bcd_alarm;

  logic       clk;
  logic       rst_n;
  logic       reg_we_i;
  logic [1:0] reg_addr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] rd_data_o;
  logic [6:0] cur_sec_i;
  logic [6:0] cur_min_i;
  logic [5:0] cur_hour_i;
  logic [4:0] cur_date_i;
  logic       sec_tick_i;
  logic       irq_o;

  int checks   = 0;
  int failures = 0;

  bit    exp_q[$];
  string tag_q[$];
  logic  pending;

  bcd_alarm i_bcd_alarm (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .rd_data_o(rd_data_o), .cur_sec_i(cur_sec_i),
    .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i), .cur_date_i(cur_date_i),
    .sec_tick_i(sec_tick_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) pending <= sec_tick_i;

  // monitor: pops the expectation one cycle after each tick
  always @(negedge clk) begin
    if (rst_n) begin
      if (pending) begin
        if (exp_q.size() > 0) begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (irq_o !== e) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq_o, e);
          end
        end
      end else if (irq_o !== 1'b0) begin
        checks++;
        failures++;
        $display("FAIL R11 irq without tick actual=%0b expected=0", irq_o);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    reg_addr_i = a;
    #1;
    checks++;
    if (rd_data_o !== e) begin
      failures++;
      $display("FAIL %s reg%0d actual=%02h expected=%02h", t, a, rd_data_o, e);
    end
  endtask

  task automatic tick(input bit e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    sec_tick_i = 1'b1;
    @(negedge clk);
    sec_tick_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_now(input logic [6:0] s, input logic [6:0] m,
                         input logic [5:0] h, input logic [4:0] d);
    cur_sec_i = s; cur_min_i = m; cur_hour_i = h; cur_date_i = d;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we_i = 1'b0; reg_addr_i = 2'd0; reg_wdata_i = 8'h00;
    sec_tick_i = 1'b0;
    set_now(7'h56, 7'h34, 6'h12, 5'h15);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) chk_rd(2'(i), 8'h00, "R1");
    checks++;
    if (irq_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 irq actual=%0b expected=0", irq_o);
    end
    tick(1'b0, "R1");

    // R5 load a full alarm and read it back
    wr(2'd0, 8'h56); wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
    chk_rd(2'd0, 8'h56, "R5"); chk_rd(2'd1, 8'h34, "R5");
    chk_rd(2'd2, 8'h12, "R5"); chk_rd(2'd3, 8'h15, "R5");

    // R6 monthly
    tick(1'b1, "R6");
    set_now(7'h57, 7'h34, 6'h12, 5'h15);
    tick(1'b0, "R6");
    set_now(7'h56, 7'h34, 6'h12, 5'h14);
    tick(1'b0, "R6");

    // R11 match held with no tick: monitor watches irq
    set_now(7'h56, 7'h34, 6'h12, 5'h15);
    repeat (5) @(negedge clk);
    checks++;
    if (irq_o !== 1'b0) begin
      failures++;
      $display("FAIL R11 idle actual=%0b expected=0", irq_o);
    end
    tick(1'b1, "R11");
    tick(1'b1, "R11");

    // R2 seconds/minutes legality
    wr(2'd0, 8'h60); chk_rd(2'd0, 8'h56, "R2");
    wr(2'd0, 8'h5A); chk_rd(2'd0, 8'h56, "R2");
    wr(2'd1, 8'h7F); chk_rd(2'd1, 8'h34, "R2");
    wr(2'd0, 8'h59); chk_rd(2'd0, 8'h59, "R2");
    wr(2'd0, 8'h00); chk_rd(2'd0, 8'h00, "R2");
    wr(2'd0, 8'h56);

    // R3 hours legality
    wr(2'd2, 8'h24); chk_rd(2'd2, 8'h12, "R3");
    wr(2'd2, 8'h1A); chk_rd(2'd2, 8'h12, "R3");
    wr(2'd2, 8'h23); chk_rd(2'd2, 8'h23, "R3");
    wr(2'd2, 8'h12);

    // R4 date legality
    wr(2'd3, 8'h00); chk_rd(2'd3, 8'h15, "R4");
    wr(2'd3, 8'h0A); chk_rd(2'd3, 8'h15, "R4");
    wr(2'd3, 8'h80); chk_rd(2'd3, 8'h15, "R4");
    wr(2'd3, 8'h19); chk_rd(2'd3, 8'h19, "R4");

    // R7 daily: date flagged
    wr(2'd3, 8'h95); chk_rd(2'd3, 8'h95, "R5");
    set_now(7'h56, 7'h34, 6'h12, 5'h03);
    tick(1'b1, "R7");
    set_now(7'h56, 7'h34, 6'h13, 5'h03);
    tick(1'b0, "R7");

    // R8 hourly: date and hour flagged
    wr(2'd2, 8'h92); chk_rd(2'd2, 8'h92, "R5");
    set_now(7'h56, 7'h34, 6'h05, 5'h03);
    tick(1'b1, "R8");
    set_now(7'h56, 7'h35, 6'h05, 5'h03);
    tick(1'b0, "R8");

    // R9 minutely: date, hour, minute flagged
    wr(2'd1, 8'hB4); chk_rd(2'd1, 8'hB4, "R5");
    tick(1'b1, "R9");
    set_now(7'h00, 7'h35, 6'h05, 5'h03);
    tick(1'b0, "R9");

    // R10 all flagged
    wr(2'd0, 8'hD6); chk_rd(2'd0, 8'hD6, "R5");
    tick(1'b1, "R10");
    // R10 only seconds flagged, time mismatched everywhere
    wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
    set_now(7'h01, 7'h02, 6'h03, 5'h04);
    tick(1'b1, "R10");
    // R10 minute and date flagged, not a named pattern
    wr(2'd0, 8'h56); wr(2'd1, 8'hB4); wr(2'd3, 8'h95);
    tick(1'b1, "R10");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule